// File: doc/BRIEF.md
# In-band Route Header Parser

This block sits on one input link of a time-division transit switch and watches the stream of slot words for the start of a packet. A fixed preamble word opens each packet. A route field of variable length follows it, with one 16-bit entry per hop. Each entry carries a used flag, an output link identifier and a connection identifier. The route field closes with an all-ones word, and a length word follows that.

The parser claims the first entry whose used flag is still clear. It sets the flag in the forwarded copy of the stream and raises a setup-request strobe that carries the entry's link and connection identifiers. It then reads the length word and holds a connection-active level for exactly that many valid payload words. A release strobe marks the end of the connection. A packet whose route field has no free entry raises an error strobe, issues no setup request and opens no connection. A preamble word that arrives while a connection is held is taken as payload. The surrounding switch performs the table lookup, the slot allocation and the switching.

Top module: `route_hdr_parser`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe, `conn_active` and `out_valid` are low, and `setup_link` and `setup_conn` are zero.
- R2: Parsing starts only on a valid word equal to 16'hA5A5 that arrives while no packet is in progress. Other words, including 16'hFFFF, cause no strobe and start no connection.
- R3: An entry uses bit 0 as the used flag, bits 8:1 as the output link and bits 15:9 as the connection identifier. The first entry after the preamble with bit 0 equal to 0 is claimed. `setup_req` pulses for one cycle, one cycle after that entry is accepted, with the entry's link on `setup_link` and its connection identifier on `setup_conn`. Both values hold until the next claim.
- R4: Every input word is forwarded one cycle later on `out_word`, with `out_valid` equal to the delayed `in_valid`. Only the claimed entry is altered, and only by having bit 0 set to 1.
- R5: Entries whose bit 0 is already 1 are skipped. Once an entry has been claimed, later entries of the same route field are forwarded unchanged, so at most one setup occurs per packet.
- R6: The word 16'hFFFF ends the route field and is never claimed. The next valid word is taken as the length.
- R7: If the terminator arrives before any entry has been claimed, `hdr_error` pulses one cycle later. In that case no setup is issued, the next word is not read as a length, and the parser returns to preamble search.
- R8: For a length L > 0, `conn_active` rises one cycle after the length word. It stays high across gaps in `in_valid` and falls one cycle after the L-th valid payload word. `release_req` pulses in that same cycle.
- R9: For a length of 0, `conn_active` never rises and `release_req` pulses one cycle after the length word.
- R10: A preamble word, or any entry-shaped word, that arrives while a connection is held is counted as payload. It causes no setup and no error.
- R11: Once a connection has been released, or an error has been raised, the next preamble starts a new packet, even when it arrives back to back with the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input slot word present |
| in_word | input | 16 | Input slot word |
| out_valid | output | 1 | Forwarded word present |
| out_word | output | 16 | Forwarded word, with the claimed entry marked used |
| setup_req | output | 1 | One-cycle connection setup request |
| setup_link | output | 8 | Output link identifier of the claimed entry |
| setup_conn | output | 7 | Connection identifier of the claimed entry |
| release_req | output | 1 | One-cycle connection release |
| conn_active | output | 1 | Connection held for payload |
| hdr_error | output | 1 | Route field held no free entry |

## Verification
The hardest situation to reach is a word that looks like a header arriving in the middle of a held connection. This means a preamble, a free entry or a terminator, each of which must be taken as payload, sometimes with gaps in `in_valid` so the count has to stall. The stimulus builds packets whose payload deliberately contains these words. It also sends packets back to back, so that a new preamble lands in the cycle right after a release. A behavioural model in the bench predicts every output on every clock, and per-packet strobe counts confirm that each packet yields exactly one setup or exactly one error.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ROUTE = 2'd1,
    ST_LEN   = 2'd2,
    ST_HOLD  = 2'd3
  } rhp_state_t;
endpackage

// File: rtl/rhp_entry_mark.sv
// Decodes one route entry and produces its marked (used) copy.
module rhp_entry_mark #(
  parameter int LINK_W = 8,
  parameter int CONN_W = 7,
  localparam int WORD_W = 1 + LINK_W + CONN_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_term,
  output logic              is_free,
  output logic [LINK_W-1:0] link,
  output logic [CONN_W-1:0] conn,
  output logic [WORD_W-1:0] marked
);
  always_comb begin
    is_term = &word;
    is_free = ~word[0];
    link    = word[LINK_W:1];
    conn    = word[WORD_W-1:LINK_W+1];
    marked  = {word[WORD_W-1:1], 1'b1};
  end
endmodule

// File: rtl/rhp_len_counter.sv
// Payload word counter: loaded from the length field, counts down on valid words.
module rhp_len_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == LEN_W'(1));

  // R8: a payload word is never counted once the count is exhausted
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> cnt != '0);
endmodule

// File: rtl/route_hdr_parser.sv
module route_hdr_parser
  import rhp_pkg::*;
#(
  parameter int LINK_W = 8,
  parameter int CONN_W = 7,
  localparam int WORD_W = 1 + LINK_W + CONN_W,
  parameter logic [WORD_W-1:0] PREAMBLE = WORD_W'(16'hA5A5)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              setup_req,
  output logic [LINK_W-1:0] setup_link,
  output logic [CONN_W-1:0] setup_conn,
  output logic              release_req,
  output logic              conn_active,
  output logic              hdr_error
);
  rhp_state_t        state;
  logic              claimed;
  logic              e_term, e_free;
  logic [LINK_W-1:0] e_link;
  logic [CONN_W-1:0] e_conn;
  logic [WORD_W-1:0] e_marked;
  logic              len_load, len_dec, len_last, len_zero;

  rhp_entry_mark #(.LINK_W(LINK_W), .CONN_W(CONN_W)) i_mark (
    .word    (in_word),
    .is_term (e_term),
    .is_free (e_free),
    .link    (e_link),
    .conn    (e_conn),
    .marked  (e_marked)
  );

  assign len_load = (state == ST_LEN)  && in_valid;
  assign len_dec  = (state == ST_HOLD) && in_valid;
  assign len_zero = (in_word == '0);

  rhp_len_counter #(.LEN_W(WORD_W)) i_len (
    .clk      (clk),
    .rst      (rst),
    .load     (len_load),
    .load_val (in_word),
    .dec      (len_dec),
    .last     (len_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_HUNT;
      claimed     <= 1'b0;
      out_valid   <= 1'b0;
      out_word    <= '0;
      setup_req   <= 1'b0;
      setup_link  <= '0;
      setup_conn  <= '0;
      release_req <= 1'b0;
      conn_active <= 1'b0;
      hdr_error   <= 1'b0;
    end else begin
      setup_req   <= 1'b0;
      release_req <= 1'b0;
      hdr_error   <= 1'b0;
      out_valid   <= in_valid;
      out_word    <= in_word;
      case (state)
        ST_HUNT: begin
          if (in_valid && in_word == PREAMBLE) begin
            state   <= ST_ROUTE;
            claimed <= 1'b0;
          end
        end
        ST_ROUTE: begin
          if (in_valid) begin
            if (e_term) begin
              if (claimed) begin
                state <= ST_LEN;
              end else begin
                hdr_error <= 1'b1;
                state     <= ST_HUNT;
              end
            end else if (!claimed && e_free) begin
              claimed    <= 1'b1;
              setup_req  <= 1'b1;
              setup_link <= e_link;
              setup_conn <= e_conn;
              out_word   <= e_marked;
            end
          end
        end
        ST_LEN: begin
          if (in_valid) begin
            if (len_zero) begin
              release_req <= 1'b1;
              state       <= ST_HUNT;
            end else begin
              conn_active <= 1'b1;
              state       <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (in_valid && len_last) begin
            conn_active <= 1'b0;
            release_req <= 1'b1;
            state       <= ST_HUNT;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R4: a setup request always comes with the forwarded entry carrying its used flag
  a_r4_claim_marked: assert property (@(posedge clk) disable iff (rst)
    setup_req |-> (out_valid && out_word[0]));

  // R7: setup, release and error never coincide
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({setup_req, release_req, hdr_error}));

  // R8: release ends the held connection
  a_r8_release_drops: assert property (@(posedge clk) disable iff (rst)
    release_req |-> !conn_active);

  // R8: an idle input cycle never ends a held connection
  a_r8_gap_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !in_valid) |=> conn_active);

  // R10: nothing seen during a held connection produces a setup or error
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> (!setup_req && !hdr_error));
endmodule

// File: tb/test_route_hdr_parser.sv
module test_route_hdr_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        out_valid, setup_req, release_req, conn_active, hdr_error;
  logic [15:0] out_word;
  logic [7:0]  setup_link;
  logic [6:0]  setup_conn;

  int checks = 0;
  int errors = 0;
  bit armed  = 1'b0;

  route_hdr_parser i_route_hdr_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word), .setup_req(setup_req),
    .setup_link(setup_link), .setup_conn(setup_conn), .release_req(release_req),
    .conn_active(conn_active), .hdr_error(hdr_error)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int          m_mode = 0;
  bit          m_claimed = 0;
  int          m_rem = 0;
  logic        x_ov = 0, x_setup = 0, x_rel = 0, x_act = 0, x_err = 0;
  logic [15:0] x_ow = 0;
  logic [7:0]  x_link = 0;
  logic [6:0]  x_conn = 0;

  always @(posedge clk) begin
    x_setup = 0; x_rel = 0; x_err = 0;
    x_ov = in_valid; x_ow = in_word;
    if (rst) begin
      m_mode = 0; m_claimed = 0; m_rem = 0;
      x_ov = 0; x_ow = 0; x_act = 0; x_link = 0; x_conn = 0;
    end else if (in_valid) begin
      if (m_mode == 0) begin
        if (in_word == 16'hA5A5) begin m_mode = 1; m_claimed = 0; end
      end else if (m_mode == 1) begin
        if (in_word == 16'hFFFF) begin
          if (m_claimed) m_mode = 2;
          else begin x_err = 1; m_mode = 0; end
        end else if (!m_claimed && in_word[0] == 1'b0) begin
          m_claimed = 1; x_setup = 1;
          x_link = in_word[8:1]; x_conn = in_word[15:9];
          x_ow = in_word | 16'h0001;
        end
      end else if (m_mode == 2) begin
        m_rem = int'(in_word);
        if (m_rem == 0) begin x_rel = 1; m_mode = 0; end
        else begin x_act = 1; m_mode = 3; end
      end else begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin x_act = 0; x_rel = 1; m_mode = 0; end
      end
    end
  end

  int n_setup = 0, n_rel = 0, n_err = 0;

  always @(negedge clk) begin
    if (armed) begin
      chk("R4", "out_valid", out_valid, x_ov);
      chk("R4", "out_word", out_word, x_ow);
      chk("R3", "setup_req", setup_req, x_setup);
      chk("R3", "setup_link", setup_link, x_link);
      chk("R3", "setup_conn", setup_conn, x_conn);
      chk("R8", "conn_active", conn_active, x_act);
      chk("R8", "release_req", release_req, x_rel);
      chk("R7", "hdr_error", hdr_error, x_err);
      n_setup += int'(setup_req);
      n_rel   += int'(release_req);
      n_err   += int'(hdr_error);
    end
  end

  task automatic put(input logic v, input logic [15:0] w);
    @(negedge clk);
    in_valid = v;
    in_word  = v ? w : 16'h0000;
  endtask

  function automatic logic [15:0] ent(input logic [6:0] c, input logic [7:0] l, input logic used);
    return {c, l, used};
  endfunction

  task automatic expect_counts(input string req, input int s0, input int r0, input int e0,
                               input int ds, input int dr, input int de);
    put(0, 0); put(0, 0);
    chk(req, "setup count", n_setup - s0, ds);
    chk(req, "release count", n_rel - r0, dr);
    chk(req, "error count", n_err - e0, de);
  endtask

  initial begin
    int s0, r0, e0;
    repeat (3) @(negedge clk);
    chk("R1", "setup_req in reset", setup_req, 0);
    chk("R1", "conn_active in reset", conn_active, 0);
    chk("R1", "out_valid in reset", out_valid, 0);
    armed = 1'b1;
    rst = 1'b0;
    put(0, 0);
    chk("R1", "release_req after reset", release_req, 0);
    chk("R1", "setup_link after reset", setup_link, 0);

    // R2: noise before any preamble, including the terminator value
    s0 = n_setup; r0 = n_rel; e0 = n_err;
    put(1, 16'h1234); put(1, 16'hFFFF); put(1, 16'h0002); put(1, 16'h0000);
    expect_counts("R2", s0, r0, e0, 0, 0, 0);
    chk("R2", "no connection from noise", conn_active, 0);

    // R3 R5 R6 R8: used entry skipped, second claimed, third left alone, gaps in payload
    s0 = n_setup; r0 = n_rel; e0 = n_err;
    put(1, 16'hA5A5);
    put(1, ent(7'h11, 8'h22, 1'b1));
    put(1, ent(7'h15, 8'h3C, 1'b0));
    put(0, 0);
    put(1, ent(7'h01, 8'h07, 1'b0));
    put(1, 16'hFFFF);
    put(1, 16'd3);
    put(1, 16'hBEEF); put(0, 0); put(0, 0); put(1, 16'hCAFE); put(1, 16'h0001);
    expect_counts("R5", s0, r0, e0, 1, 1, 0);
    chk("R3", "held link", setup_link, 8'h3C);
    chk("R3", "held conn", setup_conn, 7'h15);

    // R7: all entries used, then a word that must not be read as length
    s0 = n_setup; r0 = n_rel; e0 = n_err;
    put(1, 16'hA5A5);
    put(1, ent(7'h02, 8'h05, 1'b1));
    put(1, ent(7'h03, 8'h06, 1'b1));
    put(1, 16'hFFFF);
    put(1, 16'd5);
    put(1, 16'h0000);
    expect_counts("R7", s0, r0, e0, 0, 0, 1);
    chk("R7", "no connection after error", conn_active, 0);

    // R7: empty route field
    s0 = n_setup; r0 = n_rel; e0 = n_err;
    put(1, 16'hA5A5); put(1, 16'hFFFF);
    expect_counts("R7", s0, r0, e0, 0, 0, 1);

    // R9: zero length
    s0 = n_setup; r0 = n_rel; e0 = n_err;
    put(1, 16'hA5A5); put(1, ent(7'h7F, 8'hFF, 1'b0)); put(1, 16'hFFFF); put(1, 16'd0);
    expect_counts("R9", s0, r0, e0, 1, 1, 0);

    // R10: header-like words inside payload, then R11 back-to-back packet
    s0 = n_setup; r0 = n_rel; e0 = n_err;
    put(1, 16'hA5A5); put(1, ent(7'h0A, 8'h40, 1'b0)); put(1, 16'hFFFF); put(1, 16'd4);
    put(1, 16'hA5A5); put(1, ent(7'h0B, 8'h41, 1'b0)); put(1, 16'hFFFF); put(1, 16'd9);
    put(1, 16'hA5A5); put(1, ent(7'h33, 8'h81, 1'b0)); put(1, 16'hFFFF); put(1, 16'd1);
    put(1, 16'h5555);
    expect_counts("R10", s0, r0, e0, 2, 2, 0);
    chk("R11", "second packet link", setup_link, 8'h81);
    chk("R11", "second packet conn", setup_conn, 7'h33);

    // R1: reset in the middle of a held connection
    put(1, 16'hA5A5); put(1, ent(7'h01, 8'h01, 1'b0)); put(1, 16'hFFFF); put(1, 16'd50);
    put(1, 16'h0001);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1", "conn_active after mid-packet reset", conn_active, 0);
    rst = 1'b0;
    repeat (3) put(0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule